// File: doc/BRIEF.md
# Memory Bus Bandwidth Monitor

This block watches a shared memory bus and measures how much data crosses it. Every bus clock cycle the bus side presents the number of bytes moved in that cycle. The monitor adds these counts into an accumulator over a measurement window. It keeps the largest window total seen since the last clear as a peak value. A frequency-scaling agent can read that value to judge how busy the memory is.

Time is kept in ticks. A programmable prescaler divides the bus clock into ticks, so loading the bus frequency in MHz minus one gives one tick per microsecond. A window lasts a programmed number of ticks. At the end of each window the total is scaled to bytes, KiB or MiB, compared with the held peak, and dropped. Software restarts a measurement by turning the enable bit off and then on again. The rising edge of enable clears every counter.

The register interface is a simple word-wide port. Offset 0 is the prescaler, offset 1 is the configuration word, and offset 2 is the read-only peak. Reads are combinational from the offset.

Top module: `bw_monitor`

## Requirements
- R1: The prescaler register (offset 0, bits PRE_W-1:0) holds the divide ratio minus one. While counting, one tick is produced every prescaler+1 bus cycles.
- R2: A window ends on the cycle of its (L+1)-th tick, where L is the window field. The peak is evaluated at that cycle from the bytes of the earlier cycles of the window. That cycle's own transfer starts the next window's total, so no bytes are lost.
- R3: Configuration bits 2:1 select the unit applied to each window total at its boundary: 0 = bytes, 1 = KiB (total shifted right by 10), 2 or 3 = MiB (shifted right by 20). Remainders below one unit are kept until the boundary.
- R4: Configuration bit 0 is the enable. While it is 0, transfers are ignored and the peak holds its value.
- R5: On a 0-to-1 change of the enable, the accumulator, the peak and the tick and window counters all clear. The transfer presented in that clearing cycle is discarded.
- R6: The peak reports the largest scaled window total since the last clear. A window with a smaller or equal total leaves it unchanged.
- R7: A scaled total above the peak width saturates the peak at all ones rather than wrapping.
- R8: A configuration write that leaves the enable set changes the parameters but clears nothing.
- R9: After reset the prescaler reads 0, the enable is 0 and the peak reads 0. Writes to offset 2 have no effect.
- R10: The configuration word carries the window length minus one from bit 16 upward. Its reset value is 49999, a window of 50000 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset (0 prescaler, 1 configuration, 2 peak) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| xfer_bytes | input | XFER_W | Bytes transferred on the bus this cycle |

## Verification
The bench runs windows with constant traffic. The first window after a clear is one cycle short, so a design that counted the boundary cycle twice or dropped it would report a wrong peak once a second window completes. Runs that stop one cycle before a window boundary catch an off-by-one in the prescaler or window compare. Runs in KiB and MiB mode catch a wrong unit shift. A byte-mode run that overflows the narrowed peak catches a design that wraps instead of saturating. Directed steps then check three further corner cases. A configuration write while enabled must not clear the held peak. Traffic while disabled must not move it. Re-enabling must zero it.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam logic [1:0] ADDR_PRESC = 2'd0;
  localparam logic [1:0] ADDR_CFG   = 2'd1;
  localparam logic [1:0] ADDR_PEAK  = 2'd2;

  localparam int CFG_WIN_LSB = 16;

  typedef enum logic [1:0] {
    UNIT_BYTE = 2'd0,
    UNIT_KIB  = 2'd1,
    UNIT_MIB  = 2'd2,
    UNIT_MIB2 = 2'd3
  } unit_e;

  function automatic int unsigned unit_shift(unit_e u);
    case (u)
      UNIT_BYTE: return 0;
      UNIT_KIB:  return 10;
      default:   return 20;
    endcase
  endfunction
endpackage

// File: rtl/bwm_regs.sv
module bwm_regs
  import bwm_pkg::*;
#(
  parameter int PRE_W   = 16,
  parameter int WIN_W   = 16,
  parameter int WIN_RST = 49999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [PRE_W-1:0] presc,
  output logic [WIN_W-1:0] win_len,
  output unit_e            unit,
  output logic             en,
  output logic             clr
);
  logic [PRE_W-1:0] presc_q, presc_d;
  logic [WIN_W-1:0] win_q, win_d;
  unit_e            unit_q, unit_d;
  logic             en_q, en_d, en_prev_q;
  logic             wdata_unused;

  assign wdata_unused = &{1'b0, wdata};

  always_comb begin
    presc_d = presc_q;
    win_d   = win_q;
    unit_d  = unit_q;
    en_d    = en_q;
    if (wr && addr == ADDR_PRESC) begin
      presc_d = wdata[PRE_W-1:0];
    end
    if (wr && addr == ADDR_CFG) begin
      win_d  = wdata[CFG_WIN_LSB +: WIN_W];
      unit_d = unit_e'(wdata[2:1]);
      en_d   = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q   <= '0;
      win_q     <= WIN_W'(WIN_RST);
      unit_q    <= UNIT_BYTE;
      en_q      <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      presc_q   <= presc_d;
      win_q     <= win_d;
      unit_q    <= unit_d;
      en_q      <= en_d;
      en_prev_q <= en_q;
    end
  end

  assign presc   = presc_q;
  assign win_len = win_q;
  assign unit    = unit_q;
  assign en      = en_q;
  assign clr     = en_q & ~en_prev_q;

  AST_CLR_AFTER_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_CFG && wdata[0] && !en_q) |=> clr) else $error("clr missing"); // R5
  AST_NO_CLR_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> !clr) else $error("clr while enabled"); // R8
endmodule

// File: rtl/bwm_ticker.sv
module bwm_ticker #(
  parameter int PRE_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             clr,
  input  logic [PRE_W-1:0] presc,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             tick;
  logic             cnt_ce;

  assign tick    = active && (pre_q >= presc);
  assign win_end = tick && (win_q >= win_len);
  assign cnt_ce  = active | clr;

  always_comb begin
    pre_d = pre_q;
    win_d = win_q;
    if (clr) begin
      pre_d = '0;
      win_d = '0;
    end else if (active) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        win_d = win_end ? '0 : win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (cnt_ce) begin
      pre_q <= pre_d;
      win_q <= win_d;
    end
  end

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0)) else $error("prescaler not restarted"); // R1
  AST_CLEAR_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0 && win_q == '0)) else $error("counters not cleared"); // R5
endmodule

// File: rtl/bwm_accum.sv
module bwm_accum
  import bwm_pkg::*;
#(
  parameter int XFER_W = 16,
  parameter int ACC_W  = 40,
  parameter int PEAK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              clr,
  input  logic              win_end,
  input  unit_e             unit,
  input  logic [XFER_W-1:0] xfer,
  output logic [PEAK_W-1:0] peak
);
  localparam logic [ACC_W-1:0] PEAK_MAX = {{(ACC_W-PEAK_W){1'b0}}, {PEAK_W{1'b1}}};

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [PEAK_W-1:0] peak_q, peak_d;
  logic [ACC_W-1:0]  scaled;
  logic [PEAK_W-1:0] clipped;
  logic              acc_ce;

  assign scaled  = acc_q >> unit_shift(unit);
  assign clipped = (scaled > PEAK_MAX) ? {PEAK_W{1'b1}} : scaled[PEAK_W-1:0];
  assign acc_ce  = active | clr;

  always_comb begin
    acc_d  = acc_q;
    peak_d = peak_q;
    if (clr) begin
      acc_d  = '0;
      peak_d = '0;
    end else if (active) begin
      acc_d = win_end ? ACC_W'(xfer) : acc_q + ACC_W'(xfer);
      if (win_end && clipped > peak_q) begin
        peak_d = clipped;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      peak_q <= '0;
    end else if (acc_ce) begin
      acc_q  <= acc_d;
      peak_q <= peak_d;
    end
  end

  assign peak = peak_q;

  AST_PEAK_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (peak_q >= $past(peak_q))) else $error("peak decreased"); // R6
  AST_PEAK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (peak_q == '0 && acc_q == '0)) else $error("peak not cleared"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> $stable(peak_q)) else $error("peak moved while idle"); // R4
  AST_BOUNDARY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (acc_q == ACC_W'($past(xfer)))) else $error("boundary bytes lost"); // R2
endmodule

// File: rtl/bw_monitor.sv
module bw_monitor
  import bwm_pkg::*;
#(
  parameter int XFER_W  = 16,
  parameter int ACC_W   = 40,
  parameter int PEAK_W  = 32,
  parameter int PRE_W   = 16,
  parameter int WIN_W   = 16,
  parameter int WIN_RST = 49999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [XFER_W-1:0] xfer_bytes
);
  logic [PRE_W-1:0]  presc;
  logic [WIN_W-1:0]  win_len;
  unit_e             unit;
  logic              en, clr, active, win_end;
  logic [PEAK_W-1:0] peak;

  assign active = en & ~clr;

  bwm_regs #(.PRE_W(PRE_W), .WIN_W(WIN_W), .WIN_RST(WIN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .presc(presc), .win_len(win_len), .unit(unit), .en(en), .clr(clr)
  );

  bwm_ticker #(.PRE_W(PRE_W), .WIN_W(WIN_W)) u_ticker (
    .clk(clk), .rst_n(rst_n), .active(active), .clr(clr),
    .presc(presc), .win_len(win_len), .win_end(win_end)
  );

  bwm_accum #(.XFER_W(XFER_W), .ACC_W(ACC_W), .PEAK_W(PEAK_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .active(active), .clr(clr), .win_end(win_end),
    .unit(unit), .xfer(xfer_bytes), .peak(peak)
  );

  always_comb begin
    case (reg_addr)
      ADDR_PRESC: reg_rdata = 32'(presc);
      ADDR_CFG:   reg_rdata = (32'(win_len) << CFG_WIN_LSB) | (32'(unit) << 1) | 32'(en);
      ADDR_PEAK:  reg_rdata = 32'(peak);
      default:    reg_rdata = '0;
    endcase
  end

  AST_CFG_WRITE_KEEPS_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CFG && en && reg_wdata[0] && !win_end) |=> $stable(peak))
    else $error("config write disturbed peak"); // R8
endmodule

// File: tb/bw_monitor_bench.sv
`timescale 1ns/1ps
module bw_monitor_bench;
  localparam int XW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [XW-1:0] xfer_bytes;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  bw_monitor #(.XFER_W(XW), .ACC_W(32), .PEAK_W(PW)) u_bw_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_bytes(xfer_bytes)
  );

  // columns: prescaler, window-1, unit, bytes per cycle, counting cycles
  localparam int unsigned VEC [8][5] = '{
    '{0, 3,    0, 5,   4},     // R2 first window one cycle short
    '{0, 3,    0, 5,   3},     // R2 window not yet closed
    '{0, 3,    0, 5,   12},    // R2 R6 carried boundary cycle
    '{2, 1,    0, 7,   6},     // R1 prescaled window
    '{2, 1,    0, 7,   13},    // R1 second window
    '{0, 99,   1, 200, 200},   // R3 KiB
    '{0, 4199, 2, 255, 8400},  // R3 MiB
    '{0, 299,  0, 255, 600}    // R7 saturation
  };

  function automatic logic [31:0] cfg(int unsigned w, int unsigned u, bit e);
    return (32'(w) << 16) | (32'(u) << 1) | 32'(e);
  endfunction

  function automatic longint expect_peak(int unsigned p, int unsigned w, int unsigned u,
                                         int unsigned b, int unsigned r);
    longint n, tot, s;
    n = longint'(p + 1) * longint'(w + 1);
    if (r < n) return 0;
    tot = (r >= 2 * n) ? n * b : (n - 1) * b;
    s = (u == 0) ? (tot) : (u == 1) ? (tot >> 10) : (tot >> 20);
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_case(int unsigned p, int unsigned w, int unsigned u,
                          int unsigned b, int unsigned r);
    xfer_bytes = '0;
    wr(2'd0, 32'(p));
    wr(2'd1, cfg(w, u, 1'b0));
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = cfg(w, u, 1'b1); xfer_bytes = XW'(b);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (r) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = cfg(w, u, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; xfer_bytes = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; xfer_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R9 prescaler reset", v, 32'd0);
    rd(2'd1, v); chk("R10 config reset window", v, 32'd49999 << 16);
    rd(2'd2, v); chk("R9 peak reset", v, 32'd0);
    @(negedge clk);
    wr(2'd2, 32'h1234);
    rd(2'd2, v); chk("R9 peak read-only", v, 32'd0);
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      rd(2'd2, v);
      chk($sformatf("R1 R2 R3 R6 R7 vector %0d", i), v,
          32'(expect_peak(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4])));
      @(negedge clk);
    end

    // hold, no clear while enabled, idle, re-enable
    wr(2'd0, 32'd0);
    wr(2'd1, cfg(3, 0, 1'b0));
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = cfg(3, 0, 1'b1); xfer_bytes = 8'd5;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (8) @(negedge clk);
    xfer_bytes = '0;
    @(negedge clk);
    rd(2'd2, v); chk("R2 R6 two windows", v, 32'd20);
    @(negedge clk);
    wr(2'd1, cfg(3, 1, 1'b1));
    repeat (12) @(negedge clk);
    rd(2'd2, v); chk("R8 enabled config write keeps peak", v, 32'd20);
    rd(2'd1, v); chk("R8 config readback", v, cfg(3, 1, 1'b1));
    @(negedge clk);
    wr(2'd1, cfg(3, 0, 1'b0));
    xfer_bytes = 8'd200;
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R4 disabled ignores traffic", v, 32'd20);
    @(negedge clk);
    xfer_bytes = '0;
    wr(2'd1, cfg(3, 0, 1'b1));
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R5 re-enable clears peak", v, 32'd0);
    @(negedge clk);
    wr(2'd1, cfg(3, 0, 1'b0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule